// File: doc/BRIEF.md
# 16-bit Multicycle Processor Core

This block is a compact multicycle processor for a 16-bit, word-addressed instruction set. Each instruction moves through fetch, latch, execute and, for loads and indirect accesses, one or two extra memory states. All traffic goes through a single synchronous memory port. The port offers an address, write data and a write enable, and returns read data one clock after an address is presented. The core holds a program counter, eight 16-bit general registers and a three-bit condition register.

The supported operations are addition, bitwise AND and NOT, direct, base-relative and indirect loads and stores, load-effective-address, conditional branch, register jump and a halt word. On the halt word the core raises `halted` and stops accessing memory until the next reset. Encodings are not checked for legality. Unused bits are ignored, and any opcode outside the supported set simply advances the program counter.

Top module: `cpu16_core`

## Requirements
- R1: While reset is asserted, and right after it is released, the core presents address 3000 hex, keeps `mem_we` low and keeps `halted` low. The first instruction is fetched from 3000 hex.
- R2: Opcode 0001 adds and opcode 0101 ANDs. The destination is in bits 11..9 and the first source in bits 8..6. When bit 5 is 0 the second operand is the register in bits 2..0. When bit 5 is 1 it is bits 4..0 sign-extended. Opcode 1001 writes the bitwise inverse of the source in bits 8..6 to the destination in bits 11..9.
- R3: Every register write sets the condition register to one-hot negative (bit 2), zero (bit 1) or positive (bit 0) from the written value. This covers arithmetic, loads and load-effective-address. Opcode 0000 branches to PC+1+SX(bits 8..0) when bits 11..9 AND the condition register is non-zero. A zero mask never branches.
- R4: Opcode 0010 loads from PC+1+SX(bits 8..0). Opcode 0110 loads from base (bits 8..6) + SX(bits 5..0). Opcode 1110 writes the address PC+1+SX(bits 8..0) itself to the destination.
- R5: Opcode 1010 reads a pointer at PC+1+SX(bits 8..0), then loads from the address that pointer holds. Opcode 1011 reads the same kind of pointer, then writes the register in bits 11..9 to the pointed-to address. The pointer word is not modified.
- R6: Opcode 0011 writes the register in bits 11..9 to PC+1+SX(bits 8..0). Opcode 0111 writes it to base + SX(bits 5..0). Each store drives exactly one write cycle.
- R7: Opcode 1100 loads the program counter with the register named in bits 8..6.
- R8: The word F025 hex puts the core in a halted state. In that state `halted` is high, `mem_we` stays low and `mem_addr` stays constant until reset.
- R9: Opcodes 1000, 1101, 0100, and 1111 words other than F025, execute as no-ops. They change no register and no memory, and only advance the program counter.
- R10: Read data is sampled one clock after its address. An instruction takes 3 cycles for arithmetic, load-effective-address, branch, jump, direct store and no-op. Direct and base-relative loads and indirect stores take 4 cycles, and indirect loads take 5.
- R11: Bits that an instruction does not use are ignored. Examples are bits 4..3 of a register-mode add or AND, and bits 5..0 of a NOT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Word address for the memory port |
| mem_wdata | output | 16 | Data to write |
| mem_we | output | 1 | Write strobe for the current cycle |
| mem_rdata | input | 16 | Read data, valid one cycle after its address |
| halted | output | 1 | High once the halt word has executed |

## Verification
The assertions check several properties on every cycle. Writes occur only in the execute and first indirect states. The condition register stays one-hot. Every fetch increments the program counter by one. The second indirect state is entered only for an indirect load. The halted state holds its address with no writes, and every register-file write becomes visible on the next cycle. Only the bench's scenarios can show that whole instructions compute the right values. These cover immediate and register operands, the three addressing forms, pointer chasing, taken and untaken branches with negative offsets, jumps, ignored bits, no-op opcodes and the per-instruction cycle counts. Those results are compared against an instruction-level model written in the bench.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

    localparam int XLEN  = 16;
    localparam int NREG  = 8;
    localparam int RIDX  = $clog2(NREG);
    localparam int OPW   = 4;
    localparam int CONDW = 3;

    localparam logic [OPW-1:0] OP_BR  = 4'b0000;
    localparam logic [OPW-1:0] OP_ADD = 4'b0001;
    localparam logic [OPW-1:0] OP_LD  = 4'b0010;
    localparam logic [OPW-1:0] OP_ST  = 4'b0011;
    localparam logic [OPW-1:0] OP_AND = 4'b0101;
    localparam logic [OPW-1:0] OP_LDR = 4'b0110;
    localparam logic [OPW-1:0] OP_STR = 4'b0111;
    localparam logic [OPW-1:0] OP_NOT = 4'b1001;
    localparam logic [OPW-1:0] OP_LDI = 4'b1010;
    localparam logic [OPW-1:0] OP_STI = 4'b1011;
    localparam logic [OPW-1:0] OP_JMP = 4'b1100;
    localparam logic [OPW-1:0] OP_LEA = 4'b1110;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_LATCH,
        ST_EXEC,
        ST_RD1,
        ST_RD2,
        ST_HALT
    } state_e;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_AND,
        ALU_NOT,
        ALU_PASS
    } alu_op_e;

    typedef struct packed {
        state_e              state;
        logic [XLEN-1:0]     pc;
        logic [XLEN-1:0]     ir;
        logic [CONDW-1:0]    cond;
    } core_s;

    function automatic logic [CONDW-1:0] f_cond(input logic [XLEN-1:0] v);
        logic is_zero;
        is_zero = (v == '0);
        return {v[XLEN-1], is_zero, ~v[XLEN-1] & ~is_zero};
    endfunction

endpackage

// File: rtl/cpu16_regfile.sv
module cpu16_regfile
    import cpu16_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int N  = NREG,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    input  logic [AW-1:0] raddr_c,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b,
    output logic [W-1:0]  rdata_c
);

    logic [W-1:0] regs_q [N];
    logic [W-1:0] regs_d [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we) begin
            regs_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];
    assign rdata_c = regs_q[raddr_c];

    // R2: a register write is visible on the following cycle
    a_r2_rf_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (regs_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
    import cpu16_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_AND: y = a & b;
            ALU_NOT: y = ~a;
            default: y = b;
        endcase
    end

endmodule

// File: rtl/cpu16_agu.sv
module cpu16_agu
    import cpu16_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int OFF_L = 9,
    parameter int OFF_S = 6
) (
    input  logic [W-1:0]     pc,
    input  logic [W-1:0]     base,
    input  logic [OFF_L-1:0] off_long,
    input  logic [OFF_S-1:0] off_short,
    input  logic [CONDW-1:0] mask,
    input  logic [CONDW-1:0] cond,
    output logic [W-1:0]     ea_pc,
    output logic [W-1:0]     ea_base,
    output logic             br_take
);

    logic [W-1:0] sx_long;
    logic [W-1:0] sx_short;

    assign sx_long  = {{(W-OFF_L){off_long[OFF_L-1]}}, off_long};
    assign sx_short = {{(W-OFF_S){off_short[OFF_S-1]}}, off_short};
    assign ea_pc    = pc + sx_long;
    assign ea_base  = base + sx_short;
    assign br_take  = |(mask & cond);

endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
    import cpu16_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC  = 16'h3000,
    parameter logic [XLEN-1:0] HALT_WORD = 16'hF025
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            mem_we,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            halted
);

    localparam int IMMW = 5;

    core_s c_q;
    core_s c_d;

    logic [OPW-1:0]   opc;
    logic [RIDX-1:0]  f_dst;
    logic [RIDX-1:0]  f_src1;
    logic [RIDX-1:0]  f_src2;
    logic [XLEN-1:0]  rf_a;
    logic [XLEN-1:0]  rf_b;
    logic [XLEN-1:0]  rf_c;
    logic             rf_we;
    logic [XLEN-1:0]  rf_wd;
    logic [XLEN-1:0]  alu_b;
    logic [XLEN-1:0]  alu_y;
    alu_op_e          alu_op;
    logic [XLEN-1:0]  ea_pc;
    logic [XLEN-1:0]  ea_base;
    logic             br_take;
    logic [XLEN-1:0]  addr_c;
    logic             we_c;

    assign opc    = c_q.ir[XLEN-1 -: OPW];
    assign f_dst  = c_q.ir[11:9];
    assign f_src1 = c_q.ir[8:6];
    assign f_src2 = c_q.ir[2:0];

    cpu16_regfile #(.W(XLEN), .N(NREG), .AW(RIDX)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (f_dst),
        .wdata   (rf_wd),
        .raddr_a (f_src1),
        .raddr_b (f_src2),
        .raddr_c (f_dst),
        .rdata_a (rf_a),
        .rdata_b (rf_b),
        .rdata_c (rf_c)
    );

    always_comb begin
        if (opc == OP_AND) begin
            alu_op = ALU_AND;
        end else if (opc == OP_NOT) begin
            alu_op = ALU_NOT;
        end else begin
            alu_op = ALU_ADD;
        end
    end

    assign alu_b = c_q.ir[5] ? {{(XLEN-IMMW){c_q.ir[IMMW-1]}}, c_q.ir[IMMW-1:0]} : rf_b;

    cpu16_alu #(.W(XLEN)) u_alu (
        .op (alu_op),
        .a  (rf_a),
        .b  (alu_b),
        .y  (alu_y)
    );

    cpu16_agu #(.W(XLEN), .OFF_L(9), .OFF_S(6)) u_agu (
        .pc        (c_q.pc),
        .base      (rf_a),
        .off_long  (c_q.ir[8:0]),
        .off_short (c_q.ir[5:0]),
        .mask      (c_q.ir[11:9]),
        .cond      (c_q.cond),
        .ea_pc     (ea_pc),
        .ea_base   (ea_base),
        .br_take   (br_take)
    );

    always_comb begin
        c_d    = c_q;
        rf_we  = 1'b0;
        rf_wd  = alu_y;
        addr_c = c_q.pc;
        we_c   = 1'b0;
        case (c_q.state)
            ST_FETCH: begin
                addr_c    = c_q.pc;
                c_d.state = ST_LATCH;
            end
            ST_LATCH: begin
                c_d.ir    = mem_rdata;
                c_d.pc    = c_q.pc + 1'b1;
                c_d.state = ST_EXEC;
            end
            ST_EXEC: begin
                c_d.state = ST_FETCH;
                case (opc)
                    OP_ADD, OP_AND, OP_NOT: begin
                        rf_we = 1'b1;
                        rf_wd = alu_y;
                    end
                    OP_LEA: begin
                        rf_we = 1'b1;
                        rf_wd = ea_pc;
                    end
                    OP_BR: begin
                        if (br_take) begin
                            c_d.pc = ea_pc;
                        end
                    end
                    OP_JMP: begin
                        c_d.pc = rf_a;
                    end
                    OP_LD, OP_LDI, OP_STI: begin
                        addr_c    = ea_pc;
                        c_d.state = ST_RD1;
                    end
                    OP_LDR: begin
                        addr_c    = ea_base;
                        c_d.state = ST_RD1;
                    end
                    OP_ST: begin
                        addr_c = ea_pc;
                        we_c   = 1'b1;
                    end
                    OP_STR: begin
                        addr_c = ea_base;
                        we_c   = 1'b1;
                    end
                    default: begin
                        if (c_q.ir == HALT_WORD) begin
                            c_d.state = ST_HALT;
                        end
                    end
                endcase
            end
            ST_RD1: begin
                c_d.state = ST_FETCH;
                case (opc)
                    OP_LDI: begin
                        addr_c    = mem_rdata;
                        c_d.state = ST_RD2;
                    end
                    OP_STI: begin
                        addr_c = mem_rdata;
                        we_c   = 1'b1;
                    end
                    default: begin
                        rf_we = 1'b1;
                        rf_wd = mem_rdata;
                    end
                endcase
            end
            ST_RD2: begin
                rf_we     = 1'b1;
                rf_wd     = mem_rdata;
                c_d.state = ST_FETCH;
            end
            default: begin
                c_d.state = ST_HALT;
            end
        endcase
        if (rf_we) begin
            c_d.cond = f_cond(rf_wd);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.state <= ST_FETCH;
            c_q.pc    <= RESET_PC;
            c_q.ir    <= '0;
            c_q.cond  <= 3'b010;
        end else begin
            c_q <= c_d;
        end
    end

    assign mem_addr  = addr_c;
    assign mem_we    = we_c;
    assign mem_wdata = rf_c;
    assign halted    = (c_q.state == ST_HALT);

    // R6: memory writes only leave the execute state or the first indirect state
    a_r6_write_states: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (c_q.state == ST_EXEC || c_q.state == ST_RD1));

    // R3: condition register is always exactly one of n, z, p
    a_r3_cond_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(c_q.cond) == 1);

    // R10: every fetch latch advances the program counter by one
    a_r10_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_LATCH) |=> (c_q.state == ST_EXEC && c_q.pc == $past(c_q.pc) + 16'd1));

    // R5: the second read state serves only the indirect load
    a_r5_rd2_ldi_only: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_RD2) |-> (opc == OP_LDI));

    // R8: the halted state holds its address and never writes
    a_r8_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !mem_we && $stable(mem_addr)));

endmodule

// File: tb/cpu16_core_tb.sv
`timescale 1ns/1ps
module cpu16_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = 16'h0000;
    logic        mem_we;
    logic        halted;

    always #4 clk = ~clk;

    cpu16_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .halted    (halted)
    );

    logic [15:0] ram  [0:4095];
    logic [15:0] mref [0:4095];
    logic        ld_en = 1'b0;
    logic [11:0] ld_a  = 12'h000;
    logic [15:0] ld_d  = 16'h0000;

    always @(posedge clk) begin
        if (ld_en) begin
            ram[ld_a] <= ld_d;
        end else if (mem_we) begin
            ram[mem_addr[11:0]] <= mem_wdata;
        end
        mem_rdata <= ram[mem_addr[11:0]];
    end

    int total = 0;
    int bad   = 0;

    // main program at 3000 hex; comments name the requirement each word exercises
    localparam logic [15:0] PROG [0:37] = '{
        {4'b1110, 3'd6, 9'h02F},              // R4 LEA R6 -> 3030
        {4'b0010, 3'd1, 9'h02E},              // R4 LD R1 <- [3030]
        {4'b0110, 3'd2, 3'd6, 6'd1},          // R4 LDR R2 <- [R6+1]
        {4'b0001, 3'd3, 3'd1, 1'b0, 2'b11, 3'd2}, // R2 R11 ADD reg, junk bits
        {4'b0001, 3'd4, 3'd3, 1'b1, 5'b11101},    // R2 ADD imm -3
        {4'b0101, 3'd5, 3'd4, 1'b1, 5'h0F},       // R2 AND imm
        {4'b0101, 3'd0, 3'd3, 1'b0, 2'b00, 3'd2}, // R2 AND reg
        {4'b1001, 3'd7, 3'd1, 6'b000000},         // R11 NOT with zero low bits
        {4'b1010, 3'd2, 9'h029},              // R5 LDI R2 via [3032]
        {4'b1011, 3'd3, 9'h029},              // R5 STI R3 via [3033]
        {4'b0011, 3'd4, 9'h02B},              // R6 ST R4 -> 3036
        {4'b0111, 3'd5, 3'd6, 6'd7},          // R6 STR R5 -> 3037
        16'hD123,                             // R9 no-op
        16'hF021,                             // R9 no-op
        16'h4ABC,                             // R9 no-op
        16'h8000,                             // R9 no-op
        {4'b0000, 3'b010, 9'd1},              // R3 BRz not taken (n set)
        {4'b0001, 3'd1, 3'd1, 1'b1, 5'd1},    // executes
        {4'b0000, 3'b001, 9'd1},              // R3 BRp taken
        {4'b0001, 3'd1, 3'd1, 1'b1, 5'd1},    // skipped
        {4'b0101, 3'd2, 3'd2, 1'b1, 5'd0},    // R2 = 0
        {4'b0001, 3'd2, 3'd2, 1'b1, 5'd3},    // R2 = 3
        {4'b0001, 3'd2, 3'd2, 1'b1, 5'b11111},// R2 -= 1
        {4'b0000, 3'b001, 9'h1FE},            // R3 BRp back two
        {4'b0000, 3'b000, 9'd1},              // R3 empty mask never taken
        {4'b1110, 3'd5, 9'd3},                // R4 LEA R5 -> 301D
        {4'b1100, 3'b000, 3'd5, 6'd0},        // R7 JMP R5
        {4'b0001, 3'd1, 3'd1, 1'b1, 5'd8},    // skipped
        {4'b0001, 3'd1, 3'd1, 1'b1, 5'd8},    // skipped
        {4'b0011, 3'd0, 9'h022},
        {4'b0011, 3'd1, 9'h022},
        {4'b0011, 3'd2, 9'h022},
        {4'b0011, 3'd3, 9'h022},
        {4'b0011, 3'd4, 9'h022},
        {4'b0011, 3'd5, 9'h022},
        {4'b0011, 3'd6, 9'h022},
        {4'b0011, 3'd7, 9'h022},
        16'hF025                              // R8 halt
    };

    localparam logic [31:0] DATA [0:5] = '{
        {16'h3030, 16'h0005},
        {16'h3031, 16'h0007},
        {16'h3032, 16'h3034},
        {16'h3033, 16'h3035},
        {16'h3034, 16'h8005},
        {16'h3035, 16'h0000}
    };

    // {requirement number, address to compare}
    localparam logic [19:0] CHK [0:11] = '{
        {4'd5,  16'h3035},   // R5 indirect store target
        {4'd5,  16'h3032},   // R5 pointer untouched
        {4'd6,  16'h3036},   // R6 direct store
        {4'd6,  16'h3037},   // R6 base-relative store
        {4'd2,  16'h3040},   // R2 AND register result
        {4'd7,  16'h3041},   // R7 jump skipped adds, R3 branches
        {4'd3,  16'h3042},   // R3 backward loop counter
        {4'd11, 16'h3043},   // R11 add with junk bits
        {4'd2,  16'h3044},   // R2 immediate add
        {4'd4,  16'h3045},   // R4 LEA value
        {4'd4,  16'h3046},   // R4 LEA data pointer
        {4'd11, 16'h3047}    // R11 NOT result
    };

    localparam logic [15:0] PROG_A [0:4] = '{16'h0000, 16'h8000, 16'hD000, 16'h4000, 16'hF025};

    localparam logic [15:0] PROG_B [0:4] = '{
        {4'b0010, 3'd1, 9'h02F},   // LD R1 <- [3030]
        {4'b1010, 3'd2, 9'h030},   // LDI R2 via [3032]
        {4'b0011, 3'd1, 9'h033},   // ST R1 -> 3036
        {4'b1011, 3'd2, 9'h02F},   // STI R2 via [3033]
        16'hF025
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        ld_en = 1'b1;
        ld_a  = a[11:0];
        ld_d  = d;
        mref[a[11:0]] = d;
    endtask

    task automatic put_done();
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run_to_halt(output int n);
        n = 0;
        @(negedge clk);
        rst_n = 1'b1;
        while (!halted && n < 2000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
    endtask

    // instruction-level reference model over mref
    logic [15:0] mr [8];
    logic [2:0]  mcc;

    task automatic mset(input logic [2:0] d, input logic [15:0] v);
        mr[d] = v;
        mcc = (v == 16'h0) ? 3'b010 : (v[15] ? 3'b100 : 3'b001);
    endtask

    task automatic model_run();
        logic [15:0] pc, ir, t, sx9, sx6, sx5;
        logic        done;
        pc = 16'h3000;
        mcc = 3'b010;
        done = 1'b0;
        for (int i = 0; i < 8; i++) mr[i] = 16'h0;
        for (int step = 0; step < 1000 && !done; step++) begin
            ir  = mref[pc[11:0]];
            pc  = pc + 16'd1;
            sx9 = {{7{ir[8]}}, ir[8:0]};
            sx6 = {{10{ir[5]}}, ir[5:0]};
            sx5 = {{11{ir[4]}}, ir[4:0]};
            case (ir[15:12])
                4'h1: mset(ir[11:9], mr[ir[8:6]] + (ir[5] ? sx5 : mr[ir[2:0]]));
                4'h5: mset(ir[11:9], mr[ir[8:6]] & (ir[5] ? sx5 : mr[ir[2:0]]));
                4'h9: mset(ir[11:9], ~mr[ir[8:6]]);
                4'h2: begin t = pc + sx9; mset(ir[11:9], mref[t[11:0]]); end
                4'h6: begin t = mr[ir[8:6]] + sx6; mset(ir[11:9], mref[t[11:0]]); end
                4'hA: begin t = pc + sx9; t = mref[t[11:0]]; mset(ir[11:9], mref[t[11:0]]); end
                4'hE: mset(ir[11:9], pc + sx9);
                4'h3: begin t = pc + sx9; mref[t[11:0]] = mr[ir[11:9]]; end
                4'h7: begin t = mr[ir[8:6]] + sx6; mref[t[11:0]] = mr[ir[11:9]]; end
                4'hB: begin t = pc + sx9; t = mref[t[11:0]]; mref[t[11:0]] = mr[ir[11:9]]; end
                4'h0: if ((ir[11:9] & mcc) != 3'b000) pc = pc + sx9;
                4'hC: pc = mr[ir[8:6]];
                4'hF: if (ir == 16'hF025) done = 1'b1;
                default: ;
            endcase
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        logic [15:0] held;
        logic hold_bad;
        for (int i = 0; i < 4096; i++) begin
            ram[i]  = 16'h0;
            mref[i] = 16'h0;
        end
        rst_n = 1'b0;
        for (int i = 0; i < 38; i++) put(16'h3000 + 16'(i), PROG[i]);
        for (int i = 0; i < 6; i++) put(DATA[i][31:16], DATA[i][15:0]);
        put_done();

        // R1: reset state at the ports
        check("R1 reset address", mem_addr, 16'h3000);
        check("R1 reset write enable", {15'h0, mem_we}, 16'h0);
        check("R1 reset halted", {15'h0, halted}, 16'h0);

        run_to_halt(n);
        check("R8 main program halts", {15'h0, halted}, 16'h1);
        model_run();
        for (int k = 0; k < 12; k++) begin
            string tg;
            tg = $sformatf("R%0d mem[%h]", CHK[k][19:16], CHK[k][15:0]);
            check(tg, ram[CHK[k][11:0]], mref[CHK[k][11:0]]);
        end

        // R8: halted holds address, no writes
        held = mem_addr;
        hold_bad = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mem_we || !halted || mem_addr != held) hold_bad = 1'b1;
        end
        check("R8 halt hold", {15'h0, hold_bad}, 16'h0);

        // R9 R10: four no-ops then halt take 15 cycles
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 5; i++) put(16'h3000 + 16'(i), PROG_A[i]);
        put_done();
        run_to_halt(n);
        check("R9 R10 no-op cycle count", 16'(n), 16'd15);

        // R10: LD 4 + LDI 5 + ST 3 + STI 4 + halt 3
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 5; i++) put(16'h3000 + 16'(i), PROG_B[i]);
        put_done();
        run_to_halt(n);
        check("R10 memory op cycle count", 16'(n), 16'd19);
        check("R6 direct store value", ram[12'h036], 16'h0005);
        check("R5 indirect load then store", ram[12'h035], 16'h8005);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule